// File: doc/BRIEF.md
# Outbound Parity-Carrying Bridge Path

This block carries outbound beats (write requests and read completions) from an upstream bus that has no parity to a downstream bus that protects every byte with even parity. Each beat has a 36-bit address, a 128-bit data word and a kind flag. The block computes the 16 byte-parity bits of the data once, in the cycle the beat is accepted. It then stores data and parity side by side in a buffer. On egress it presents the stored bits as they are and never rebuilds the data parity. The address parity for the downstream transfer is computed when a beat moves from the buffer into the output stage.

Both sides use valid/ready handshakes. A debug input can flip one bit of the stored data-plus-parity word after the parity has been computed. This lets a test show that egress forwards stored parity rather than recomputing it.

The egress controller has two states. In `EG_EMPTY` nothing is presented. In `EG_HOLD` a beat sits on the downstream port. There are three transitions:
- LOAD_FIRST goes from `EG_EMPTY` to `EG_HOLD` when the buffer is not empty.
- REFILL stays in `EG_HOLD` while replacing the beat; it fires when the beat is accepted and the buffer still has data.
- DRAIN goes from `EG_HOLD` to `EG_EMPTY` when the beat is accepted and the buffer is empty.

Top module: `obp_bridge`

## Requirements
- R1: During and right after reset, `dn_valid` is 0 and `up_ready` is 1.
- R2: `dn_data_par[i]` equals the XOR of bits 8i+7..8i of the data word as it was accepted upstream, so each byte and its parity bit hold an even count of ones.
- R3: `dn_addr_par[i]` for i=0..3 equals the XOR of address bits 8i+7..8i. `dn_addr_par[4]` equals the XOR of address bits 35..32 only.
- R4: Address, data and the kind flag (`up_write`, 1 = write request, 0 = read completion) arrive downstream unchanged and in acceptance order.
- R5: When `dbg_flip_en` is 1 on an accepted beat, the stored 144-bit word is inverted at bit `dbg_flip_pos`. Positions 0..127 are data bits and 128..143 are parity bits 0..15. Downstream shows the flipped bit, and all other parity bits are those computed at ingress; egress does not recompute data parity.
- R6: With `dn_ready` held at 0, exactly DEPTH+1 beats (buffer plus output stage) are accepted, and then `up_ready` stays 0.
- R7: While `dn_valid` is 1 and `dn_ready` is 0, all downstream outputs hold steady. `dn_valid` only falls after a cycle with `dn_ready` = 1.
- R8: A beat accepted at clock edge k into an idle block is first presented (`dn_valid` = 1) after edge k+1 and not before.
- R9: With `dn_ready` held at 1, a full buffer delivers one beat per cycle without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream beat valid |
| up_ready | output | 1 | Buffer can accept a beat |
| up_write | input | 1 | Kind flag: 1 write request, 0 read completion |
| up_addr | input | 36 | Upstream address |
| up_data | input | 128 | Upstream data, no parity |
| dbg_flip_en | input | 1 | Invert one stored bit of the accepted beat |
| dbg_flip_pos | input | 8 | Stored-word bit to invert (0..143) |
| dn_valid | output | 1 | Downstream beat valid |
| dn_ready | input | 1 | Downstream accepts the beat |
| dn_write | output | 1 | Kind flag of the presented beat |
| dn_addr | output | 36 | Presented address |
| dn_addr_par | output | 5 | Even byte parity of the address |
| dn_data | output | 128 | Presented data |
| dn_data_par | output | 16 | Stored data parity |

## Verification
An accepted beat passes through two registers, the buffer and the output stage. Its fields are therefore due on the downstream port one cycle after the acceptance edge plus one more, i.e. after edge k+1. The bench drives inputs and samples outputs on falling edges. It checks that `dn_valid` is still low after the acceptance edge and that the full set of fields is present after the next edge. Under backpressure it counts acceptances by sampling `up_ready` before each edge. It then opens `dn_ready` and expects a new beat at every following falling edge, in order.

// File: rtl/obp_pkg.sv
package obp_pkg;
    typedef enum logic [0:0] {
        EG_EMPTY = 1'b0,
        EG_HOLD  = 1'b1
    } eg_state_e;
endpackage

// File: rtl/obp_byte_parity.sv
module obp_byte_parity #(
    parameter int W = 128,
    localparam int NG = (W + 7) / 8
) (
    input  logic [W-1:0]  din,
    output logic [NG-1:0] par
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LO = g * 8;
        localparam int HI = (LO + 7 < W) ? LO + 7 : W - 1;
        assign par[g] = ^din[HI:LO];
    end
endmodule

// File: rtl/obp_fifo.sv
module obp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R4
endmodule

// File: rtl/obp_bridge.sv
module obp_bridge
    import obp_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ADDR_W = 36,
    parameter int DEPTH  = 8,
    localparam int DP_N    = (DATA_W + 7) / 8,
    localparam int AP_N    = (ADDR_W + 7) / 8,
    localparam int STORE_W = DATA_W + DP_N,
    localparam int ENT_W   = 1 + ADDR_W + STORE_W,
    localparam int POS_W   = $clog2(STORE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_data,
    input  logic              dbg_flip_en,
    input  logic [POS_W-1:0]  dbg_flip_pos,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [AP_N-1:0]   dn_addr_par,
    output logic [DATA_W-1:0] dn_data,
    output logic [DP_N-1:0]   dn_data_par
);
    // Ingress: data parity is formed here, once.
    logic [DP_N-1:0]    in_par;
    logic [STORE_W-1:0] flip_mask, in_store;
    logic [ENT_W-1:0]   in_ent, head_ent;
    logic               fifo_full, fifo_empty, push, load;

    obp_byte_parity #(.W(DATA_W)) u_dpar (.din(up_data), .par(in_par));

    assign flip_mask = dbg_flip_en ? (STORE_W'(1) << dbg_flip_pos) : '0;
    assign in_store  = {in_par, up_data} ^ flip_mask;
    assign in_ent    = {up_write, up_addr, in_store};
    assign up_ready  = !fifo_full;
    assign push      = up_valid && up_ready;

    obp_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (in_ent),
        .rd_en   (load),
        .rd_data (head_ent),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    // Egress: address parity from the head entry; data parity passed through.
    logic [ADDR_W-1:0] head_addr;
    logic [AP_N-1:0]   head_apar;
    assign head_addr = head_ent[STORE_W +: ADDR_W];

    obp_byte_parity #(.W(ADDR_W)) u_apar (.din(head_addr), .par(head_apar));

    eg_state_e state, state_nx;

    assign load = !fifo_empty && (state == EG_EMPTY || dn_ready);

    always_comb begin
        state_nx = state;
        unique case (state)
            EG_EMPTY: if (!fifo_empty)             state_nx = EG_HOLD;   // LOAD_FIRST
            EG_HOLD:  if (dn_ready && fifo_empty)  state_nx = EG_EMPTY;  // DRAIN
            default:                               state_nx = EG_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= EG_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_write    <= 1'b0;
            dn_addr     <= '0;
            dn_addr_par <= '0;
            dn_data     <= '0;
            dn_data_par <= '0;
        end else if (load) begin  // LOAD_FIRST or REFILL
            dn_write    <= head_ent[ENT_W-1];
            dn_addr     <= head_addr;
            dn_addr_par <= head_apar;
            dn_data     <= head_ent[DATA_W-1:0];
            dn_data_par <= head_ent[DATA_W +: DP_N];
        end
    end

    assign dn_valid = (state == EG_HOLD);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) &&
            $stable(dn_data_par) && $stable(dn_addr) && $stable(dn_addr_par))); // R7
    AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_valid) |-> $past(dn_ready)); // R7
endmodule

// File: tb/obp_bridge_tb.sv
module obp_bridge_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         up_valid, up_ready, up_write;
    logic [35:0]  up_addr;
    logic [127:0] up_data;
    logic         dbg_flip_en;
    logic [7:0]   dbg_flip_pos;
    logic         dn_valid, dn_ready, dn_write;
    logic [35:0]  dn_addr;
    logic [4:0]   dn_addr_par;
    logic [127:0] dn_data;
    logic [15:0]  dn_data_par;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    obp_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
        .up_write(up_write), .up_addr(up_addr), .up_data(up_data),
        .dbg_flip_en(dbg_flip_en), .dbg_flip_pos(dbg_flip_pos),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write),
        .dn_addr(dn_addr), .dn_addr_par(dn_addr_par), .dn_data(dn_data),
        .dn_data_par(dn_data_par)
    );

    localparam int NV = 6;
    localparam logic [127:0] VDATA [NV] = '{
        128'h0,
        {128{1'b1}},
        {16{8'hA5}},
        128'h0102_0408_1020_4080_0000_0000_0000_0001,
        128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE,
        128'h8000_0000_0000_0000_0000_0000_0000_0007
    };
    localparam logic [35:0] VADDR [NV] = '{
        36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'h7_0000_0001,
        36'h8_1234_5678, 36'h1_8080_8080, 36'hE_0F0F_F0F0
    };
    localparam logic VWR [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    function automatic logic [15:0] dpar(input logic [127:0] d);
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [4:0] apar(input logic [35:0] a);
        logic [4:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^a[i*8 +: 8];
        p[4] = ^a[35:32];
        return p;
    endfunction

    function automatic logic [127:0] bp_pat(input int k);
        return {32'hC0DE_0000 + 32'(k), 64'h0, 32'h5A5A_0000 ^ 32'(k * 3)};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge with dn_ready=1 and the block idle.
    task automatic send_one(input logic [35:0] a, input logic [127:0] d,
                            input logic w, input logic fe, input logic [7:0] fp,
                            input logic [127:0] exp_d, input logic [15:0] exp_p);
        up_valid = 1'b1; up_addr = a; up_data = d; up_write = w;
        dbg_flip_en = fe; dbg_flip_pos = fp;
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0; dbg_flip_en = 1'b0;
        chk(dn_valid == 1'b0, "R8 not yet valid", 160'(dn_valid), 160'(0));
        @(negedge clk);
        chk(dn_valid == 1'b1, "R8 valid after second edge", 160'(dn_valid), 160'(1));
        chk(dn_data == exp_d, "R4 data", 160'(dn_data), 160'(exp_d));
        chk(dn_data_par == exp_p, "R2 data parity", 160'(dn_data_par), 160'(exp_p));
        chk(dn_addr == a, "R4 address", 160'(dn_addr), 160'(a));
        chk(dn_addr_par == apar(a), "R3 address parity", 160'(dn_addr_par), 160'(apar(a)));
        chk(dn_write == w, "R4 kind", 160'(dn_write), 160'(w));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int accepted;
        logic [127:0] held;
        rst_n = 1'b0; up_valid = 1'b0; up_write = 1'b0; up_addr = '0; up_data = '0;
        dbg_flip_en = 1'b0; dbg_flip_pos = '0; dn_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(dn_valid == 1'b0, "R1 dn_valid in reset", 160'(dn_valid), 160'(0));
        chk(up_ready == 1'b1, "R1 up_ready in reset", 160'(up_ready), 160'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(dn_valid == 1'b0, "R1 dn_valid after reset", 160'(dn_valid), 160'(0));
        dn_ready = 1'b1;

        // Table of vectors
        for (int i = 0; i < NV; i++)
            send_one(VADDR[i], VDATA[i], VWR[i], 1'b0, 8'd0, VDATA[i], dpar(VDATA[i]));

        // R5: corrupt a data bit, then a parity bit, after ingress parity
        send_one(36'h3_0000_00FF, VDATA[4], 1'b1, 1'b1, 8'd5,
                 VDATA[4] ^ (128'd1 << 5), dpar(VDATA[4]));
        send_one(36'h3_0000_00FF, VDATA[2], 1'b0, 1'b1, 8'd130,
                 VDATA[2], dpar(VDATA[2]) ^ 16'h0004);
        send_one(36'h0_0000_0000, VDATA[1], 1'b1, 1'b1, 8'd127,
                 VDATA[1] ^ (128'd1 << 127), dpar(VDATA[1]));

        // R6: fill with downstream stalled
        @(negedge clk);
        dn_ready = 1'b0;
        accepted = 0;
        for (int k = 0; k < 14; k++) begin
            if (up_ready) begin
                up_valid = 1'b1; up_addr = 36'(k); up_write = 1'b1;
                up_data = bp_pat(accepted);
                accepted++;
            end else begin
                up_valid = 1'b0;
            end
            @(negedge clk);
        end
        up_valid = 1'b0;
        chk(accepted == 9, "R6 accepted count", 160'(accepted), 160'(9));
        chk(up_ready == 1'b0, "R6 up_ready when full", 160'(up_ready), 160'(0));

        // R7: hold while stalled
        held = dn_data;
        repeat (3) @(negedge clk);
        chk(dn_valid == 1'b1, "R7 still valid", 160'(dn_valid), 160'(1));
        chk(dn_data == held, "R7 data held", 160'(dn_data), 160'(held));

        // R9: drain back to back, in order
        dn_ready = 1'b1;
        for (int j = 0; j < 9; j++) begin
            chk(dn_valid == 1'b1, "R9 no gap", 160'(dn_valid), 160'(1));
            chk(dn_data == bp_pat(j), "R4 order", 160'(dn_data), 160'(bp_pat(j)));
            chk(dn_data_par == dpar(bp_pat(j)), "R2 parity after stall",
                160'(dn_data_par), 160'(dpar(bp_pat(j))));
            @(negedge clk);
        end
        chk(dn_valid == 1'b0, "R9 empty after drain", 160'(dn_valid), 160'(0));
        chk(up_ready == 1'b1, "R6 ready after drain", 160'(up_ready), 160'(1));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule